// File: doc/BRIEF.md
# Power Stage Fault Supervisor

This block decides, one clock at a time, whether the high-side and low-side switches of a buck power stage may run. It watches digitized samples of the input voltage, the sensed output voltage, the output setpoint and the die temperature. It holds off all protection until the supply lockout flag reports a valid supply. From then on it removes the switching enable whenever the input is too high or too low, or the die is too hot. Each of these faults restarts the stage on its own once the condition is gone.

Power-up is supervised by a tick-counted time limit. If the output does not rise above its undervoltage threshold in time, switching stops. After a programmable wait, power-up is attempted again, and this repeats until a start succeeds. Switching is also never started while the sensed output already sits above the setpoint.

Limits and times are held in a small bank written through a valid/address/data port. That port has no back-pressure: a write presented with `wr_valid` high is taken at that clock edge. Per-fault live flags and sticky flags with write-one-to-clear are provided.

Top module: `pwr_fault_sup`

## Requirements
- R1: After reset the limits are: input overvoltage 240, input turn-off 144, input turn-on 160 (input codes are 1/16 V per LSB, so 15 V, 9 V and 10 V), temperature 125 (1 °C per LSB), output undervoltage 8, power-up limit 20 ticks and retry delay 20 ticks (ticks of `tick_1k`, 1 ms each).
- R2: While `uvlo_ok` is low, `sw_en` is 0, every `flt_live` bit is 0 and no `flt_sticky` bit is set, whatever the samples are.
- R3: When `vin_code` is strictly above the overvoltage limit, `sw_en` is 0 and `flt_live[0]` is 1 after the next rising edge. When the input is at or below the limit, the stage restarts.
- R4: `flt_live[1]` (input undervoltage) sets when `vin_code` is below the turn-off limit. It stays set until `vin_code` is strictly above the turn-on limit, and `sw_en` is 0 while it is set. After supply release it starts out set, so the first start needs the input above the turn-on limit.
- R5: When `temp_code` is strictly above the temperature limit, `sw_en` is 0 and `flt_live[3]` is 1 after the next edge. The stage restarts when the temperature is at or below the limit.
- R6: While the supervisor is waiting to start and `vout_code` is strictly above `vset_code`, `sw_en` stays 0. Switching begins at the edge after the output is at or below the setpoint.
- R7: With no fault and no pre-bias, `sw_en` rises at the next edge. Power-up completes once `vout_code` is strictly above the output undervoltage limit.
- R8: If power-up has not completed, the tick that brings the count of `tick_1k` pulses seen during power-up to the power-up limit ends it. At that edge `sw_en` falls and `flt_live[2]` rises.
- R9: After a timeout, the tick that brings the count of ticks to the retry delay clears `flt_live[2]`. `sw_en` rises again at the following edge.
- R10: `flt_sticky` bits (bit 0 overvoltage, 1 undervoltage, 2 timeout, 3 temperature) set together with their fault. A write to address 7 clears the bits set in the data. A fault in the same cycle wins over the clear.
- R11: Writes to address 0 (overvoltage), 1 (turn-off), 2 (turn-on), 3 (temperature), 4 (output undervoltage), 5 (power-up limit) and 6 (retry delay) take effect from the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uvlo_ok | input | 1 | Supply lockout released |
| tick_1k | input | 1 | One-cycle 1 kHz time strobe |
| vin_code | input | DW | Input voltage sample |
| vout_code | input | DW | Sensed output voltage sample |
| vset_code | input | DW | Output setpoint |
| temp_code | input | DW | Die temperature sample |
| wr_valid | input | 1 | Register write strobe |
| wr_addr | input | AW | Register address |
| wr_data | input | RW | Register write data |
| sw_en | output | 1 | Switching allowed (registered) |
| flt_live | output | 4 | Current faults: OV, UV, timeout, OT |
| flt_sticky | output | 4 | Sticky fault flags, write-one-to-clear |

## Verification
Every result is registered once. A sample, tick or write applied before a rising edge shows up on `sw_en`, `flt_live` and `flt_sticky` right after that edge, with no extra pipeline delay. The bench applies each stimulus, waits for exactly one rising edge, and queues the expected triple for the following falling edge, where the monitor compares it. Timeout and retry results are due on the edge of a specific counted tick. The bench therefore checks every tick edge individually, and so confirms both that nothing happens early and that the event lands on the right tick.

// File: rtl/psf_pkg.sv
package psf_pkg;
  typedef enum logic [1:0] {
    ST_ARM   = 2'd0,
    ST_RAMP  = 2'd1,
    ST_UP    = 2'd2,
    ST_RETRY = 2'd3
  } sup_state_t;

  localparam int NFLT  = 4;
  localparam int F_OV  = 0;
  localparam int F_UV  = 1;
  localparam int F_TMO = 2;
  localparam int F_OT  = 3;

  localparam logic [2:0] A_OV    = 3'd0;
  localparam logic [2:0] A_VOFF  = 3'd1;
  localparam logic [2:0] A_VON   = 3'd2;
  localparam logic [2:0] A_OT    = 3'd3;
  localparam logic [2:0] A_VOUV  = 3'd4;
  localparam logic [2:0] A_TMAX  = 3'd5;
  localparam logic [2:0] A_RETRY = 3'd6;
  localparam logic [2:0] A_CLR   = 3'd7;
endpackage

// File: rtl/psf_regs.sv
module psf_regs
  import psf_pkg::*;
#(
  parameter int DW = 12,
  parameter int TW = 12,
  parameter int RW = 12,
  parameter logic [DW-1:0] OV_RST   = 240,
  parameter logic [DW-1:0] VOFF_RST = 144,
  parameter logic [DW-1:0] VON_RST  = 160,
  parameter logic [DW-1:0] OT_RST   = 125,
  parameter logic [DW-1:0] VOUV_RST = 8,
  parameter logic [TW-1:0] TMAX_RST = 20,
  parameter logic [TW-1:0] RTRY_RST = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_valid,
  input  logic [2:0]      wr_addr,
  input  logic [RW-1:0]   wr_data,
  output logic [DW-1:0]   lim_ov,
  output logic [DW-1:0]   lim_off,
  output logic [DW-1:0]   lim_on,
  output logic [DW-1:0]   lim_ot,
  output logic [DW-1:0]   lim_vuv,
  output logic [TW-1:0]   t_max,
  output logic [TW-1:0]   t_retry,
  output logic [NFLT-1:0] clr_mask
);
  logic [DW-1:0] dval;
  logic [TW-1:0] tval;

  assign dval = wr_data[DW-1:0];
  assign tval = wr_data[TW-1:0];
  assign clr_mask = (wr_valid && wr_addr == A_CLR) ? wr_data[NFLT-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_ov  <= OV_RST;
      lim_off <= VOFF_RST;
      lim_on  <= VON_RST;
      lim_ot  <= OT_RST;
      lim_vuv <= VOUV_RST;
      t_max   <= TMAX_RST;
      t_retry <= RTRY_RST;
    end else if (wr_valid) begin
      case (wr_addr)
        A_OV:    lim_ov  <= dval;
        A_VOFF:  lim_off <= dval;
        A_VON:   lim_on  <= dval;
        A_OT:    lim_ot  <= dval;
        A_VOUV:  lim_vuv <= dval;
        A_TMAX:  t_max   <= tval;
        A_RETRY: t_retry <= tval;
        default: ;
      endcase
    end
  end

  // R11
  ov_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_addr == A_OV) |=> lim_ov == $past(dval));
  // R11
  tmax_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_addr == A_TMAX) |=> t_max == $past(tval));
endmodule

// File: rtl/psf_detect.sv
module psf_detect #(
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          uvlo_ok,
  input  logic [DW-1:0] vin_code,
  input  logic [DW-1:0] temp_code,
  input  logic [DW-1:0] lim_ov,
  input  logic [DW-1:0] lim_off,
  input  logic [DW-1:0] lim_on,
  input  logic [DW-1:0] lim_ot,
  output logic          ov_now,
  output logic          uv_now,
  output logic          ot_now
);
  logic uv_hold_q;
  logic vin_low, vin_high;

  assign vin_low  = vin_code < lim_off;
  assign vin_high = vin_code > lim_on;

  assign ov_now = uvlo_ok && (vin_code > lim_ov);
  assign ot_now = uvlo_ok && (temp_code > lim_ot);
  assign uv_now = uvlo_ok && (vin_low || (uv_hold_q && !vin_high));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        uv_hold_q <= 1'b1;
    else if (!uvlo_ok) uv_hold_q <= 1'b1;
    else if (vin_low)  uv_hold_q <= 1'b1;
    else if (vin_high) uv_hold_q <= 1'b0;
  end

  // R4
  uv_hyst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (uvlo_ok && uv_hold_q && vin_code <= lim_on) |=> uv_hold_q);
  // R4
  uv_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (uvlo_ok && vin_code > lim_on && vin_code >= lim_off) |=> !uv_hold_q);
endmodule

// File: rtl/psf_startup.sv
module psf_startup
  import psf_pkg::*;
#(
  parameter int DW = 12,
  parameter int TW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          uvlo_ok,
  input  logic          tick_1k,
  input  logic          vflt,
  input  logic [DW-1:0] vout_code,
  input  logic [DW-1:0] vset_code,
  input  logic [DW-1:0] lim_vuv,
  input  logic [TW-1:0] t_max,
  input  logic [TW-1:0] t_retry,
  output logic          sw_en,
  output logic          tmo_live,
  output logic          tmo_ev
);
  sup_state_t st_q, st_n;
  logic [TW-1:0] cnt_q, cnt_n;
  logic [TW:0]   cnt_inc;
  logic          prebias, out_ok, en_d;

  assign cnt_inc = {1'b0, cnt_q} + 1'b1;
  assign prebias = vout_code > vset_code;
  assign out_ok  = vout_code > lim_vuv;

  always_comb begin
    st_n   = st_q;
    cnt_n  = cnt_q;
    tmo_ev = 1'b0;
    if (!uvlo_ok) begin
      st_n  = ST_ARM;
      cnt_n = '0;
    end else begin
      case (st_q)
        ST_ARM: if (!vflt && !prebias) begin
          st_n  = ST_RAMP;
          cnt_n = '0;
        end
        ST_RAMP: begin
          if (vflt) st_n = ST_ARM;
          else if (out_ok) st_n = ST_UP;
          else if (tick_1k) begin
            if (cnt_inc >= {1'b0, t_max}) begin
              st_n   = ST_RETRY;
              cnt_n  = '0;
              tmo_ev = 1'b1;
            end else cnt_n = cnt_inc[TW-1:0];
          end
        end
        ST_UP: if (vflt) st_n = ST_ARM;
        ST_RETRY: if (tick_1k) begin
          if (cnt_inc >= {1'b0, t_retry}) begin
            st_n  = ST_ARM;
            cnt_n = '0;
          end else cnt_n = cnt_inc[TW-1:0];
        end
        default: st_n = ST_ARM;
      endcase
    end
  end

  assign en_d = (st_n == ST_RAMP) || (st_n == ST_UP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_ARM;
      cnt_q <= '0;
      sw_en <= 1'b0;
    end else begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
      sw_en <= en_d;
    end
  end

  assign tmo_live = (st_q == ST_RETRY);

  // R6
  prebias_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ARM && prebias) |=> !sw_en);
  // R8
  retry_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RETRY) |-> !sw_en);
  // R8
  tmo_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_q == ST_RETRY) |-> $past(st_q) == ST_RAMP);
  // R2
  uvlo_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !uvlo_ok |=> (!sw_en && st_q == ST_ARM));
endmodule

// File: rtl/psf_status.sv
module psf_status #(
  parameter int NF = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] set_in,
  input  logic [NF-1:0] clr_in,
  output logic [NF-1:0] sticky
);
  for (genvar i = 0; i < NF; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         sticky[i] <= 1'b0;
      else if (set_in[i]) sticky[i] <= 1'b1;
      else if (clr_in[i]) sticky[i] <= 1'b0;
    end

    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_in[i] |=> sticky[i]);
    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_in[i] && !clr_in[i]) |=> sticky[i] == $past(sticky[i]));
  end
endmodule

// File: rtl/pwr_fault_sup.sv
module pwr_fault_sup
  import psf_pkg::*;
#(
  parameter int DW = 12,
  parameter int TW = 12,
  parameter int AW = 3,
  parameter logic [DW-1:0] OV_RST   = 240,
  parameter logic [DW-1:0] VOFF_RST = 144,
  parameter logic [DW-1:0] VON_RST  = 160,
  parameter logic [DW-1:0] OT_RST   = 125,
  parameter logic [DW-1:0] VOUV_RST = 8,
  parameter logic [TW-1:0] TMAX_RST = 20,
  parameter logic [TW-1:0] RTRY_RST = 20,
  localparam int RW = (DW > TW) ? DW : TW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            uvlo_ok,
  input  logic            tick_1k,
  input  logic [DW-1:0]   vin_code,
  input  logic [DW-1:0]   vout_code,
  input  logic [DW-1:0]   vset_code,
  input  logic [DW-1:0]   temp_code,
  input  logic            wr_valid,
  input  logic [AW-1:0]   wr_addr,
  input  logic [RW-1:0]   wr_data,
  output logic            sw_en,
  output logic [NFLT-1:0] flt_live,
  output logic [NFLT-1:0] flt_sticky
);
  logic [DW-1:0] lim_ov, lim_off, lim_on, lim_ot, lim_vuv;
  logic [TW-1:0] t_max, t_retry;
  logic [NFLT-1:0] clr_mask, set_vec;
  logic ov_now, uv_now, ot_now, tmo_live, tmo_ev;
  logic ov_q, uv_q, ot_q;

  psf_regs #(
    .DW(DW), .TW(TW), .RW(RW),
    .OV_RST(OV_RST), .VOFF_RST(VOFF_RST), .VON_RST(VON_RST),
    .OT_RST(OT_RST), .VOUV_RST(VOUV_RST),
    .TMAX_RST(TMAX_RST), .RTRY_RST(RTRY_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_addr(wr_addr[2:0]), .wr_data(wr_data),
    .lim_ov(lim_ov), .lim_off(lim_off), .lim_on(lim_on),
    .lim_ot(lim_ot), .lim_vuv(lim_vuv),
    .t_max(t_max), .t_retry(t_retry), .clr_mask(clr_mask)
  );

  psf_detect #(.DW(DW)) u_det (
    .clk(clk), .rst_n(rst_n), .uvlo_ok(uvlo_ok),
    .vin_code(vin_code), .temp_code(temp_code),
    .lim_ov(lim_ov), .lim_off(lim_off), .lim_on(lim_on), .lim_ot(lim_ot),
    .ov_now(ov_now), .uv_now(uv_now), .ot_now(ot_now)
  );

  psf_startup #(.DW(DW), .TW(TW)) u_seq (
    .clk(clk), .rst_n(rst_n), .uvlo_ok(uvlo_ok), .tick_1k(tick_1k),
    .vflt(ov_now || uv_now || ot_now),
    .vout_code(vout_code), .vset_code(vset_code), .lim_vuv(lim_vuv),
    .t_max(t_max), .t_retry(t_retry),
    .sw_en(sw_en), .tmo_live(tmo_live), .tmo_ev(tmo_ev)
  );

  always_comb begin
    set_vec        = '0;
    set_vec[F_OV]  = ov_now;
    set_vec[F_UV]  = uv_now;
    set_vec[F_TMO] = tmo_ev;
    set_vec[F_OT]  = ot_now;
  end

  psf_status #(.NF(NFLT)) u_stat (
    .clk(clk), .rst_n(rst_n),
    .set_in(set_vec), .clr_in(clr_mask), .sticky(flt_sticky)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_q <= 1'b0;
      uv_q <= 1'b0;
      ot_q <= 1'b0;
    end else begin
      ov_q <= ov_now;
      uv_q <= uv_now;
      ot_q <= ot_now;
    end
  end

  always_comb begin
    flt_live        = '0;
    flt_live[F_OV]  = ov_q;
    flt_live[F_UV]  = uv_q;
    flt_live[F_TMO] = tmo_live;
    flt_live[F_OT]  = ot_q;
  end

  // R3
  ov_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (uvlo_ok && vin_code > lim_ov) |=> (!sw_en && flt_live[F_OV]));
  // R5
  ot_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (uvlo_ok && temp_code > lim_ot) |=> (!sw_en && flt_live[F_OT]));
  // R2
  uvlo_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !uvlo_ok |=> (flt_live == '0));
  // R4
  uv_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flt_live[F_UV] |-> !sw_en);
endmodule

// File: tb/sim_pwr_fault_sup.sv
module sim_pwr_fault_sup;
  typedef struct {
    logic       en;
    logic [3:0] live;
    logic       chk_stk;
    logic [3:0] stk;
    string      req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic uvlo_ok = 1'b0;
  logic tick_1k = 1'b0;
  logic [11:0] vin_code = 12'd192;
  logic [11:0] vout_code = 12'd0;
  logic [11:0] vset_code = 12'd48;
  logic [11:0] temp_code = 12'd25;
  logic wr_valid = 1'b0;
  logic [2:0] wr_addr = 3'd0;
  logic [11:0] wr_data = 12'd0;
  logic sw_en;
  logic [3:0] flt_live, flt_sticky;

  exp_t q[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pwr_fault_sup u0 (
    .clk(clk), .rst_n(rst_n), .uvlo_ok(uvlo_ok), .tick_1k(tick_1k),
    .vin_code(vin_code), .vout_code(vout_code), .vset_code(vset_code),
    .temp_code(temp_code), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .sw_en(sw_en), .flt_live(flt_live),
    .flt_sticky(flt_sticky)
  );

  // driver: one rising edge, then queue what must be visible after it
  task automatic step(input string req, input logic en, input logic [3:0] live,
                      input logic chk_stk = 1'b0, input logic [3:0] stk = 4'h0);
    exp_t e;
    @(posedge clk);
    #1;
    e.en = en; e.live = live; e.chk_stk = chk_stk; e.stk = stk; e.req = req;
    q.push_back(e);
    wr_valid = 1'b0;
    tick_1k  = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [11:0] d);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
  endtask

  // monitor
  always @(negedge clk) begin
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_cmp++;
      if (sw_en !== e.en || flt_live !== e.live ||
          (e.chk_stk && flt_sticky !== e.stk)) begin
        n_bad++;
        $display("FAIL %s: en=%b live=%b stk=%b expected en=%b live=%b stk=%b",
                 e.req, sw_en, flt_live, flt_sticky, e.en, e.live, e.stk);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    step("R2", 1'b0, 4'h0, 1'b1, 4'h0);          // held in reset
    @(negedge clk); rst_n = 1'b1;
    step("R2", 1'b0, 4'h0, 1'b1, 4'h0);
    vin_code = 12'd255; temp_code = 12'd200;    // faults ignored before release
    step("R2", 1'b0, 4'h0, 1'b1, 4'h0);
    vin_code = 12'd192; temp_code = 12'd25;
    uvlo_ok = 1'b1;
    step("R7", 1'b1, 4'h0, 1'b1, 4'h0);          // start ramp
    vout_code = 12'd16;
    step("R7", 1'b1, 4'h0);                       // up
    vin_code = 12'd241;
    step("R3", 1'b0, 4'h1, 1'b1, 4'h1);
    vin_code = 12'd240;                           // at limit: not over (R1 default 240)
    step("R3", 1'b1, 4'h0, 1'b1, 4'h1);
    step("R3", 1'b1, 4'h0);
    wr(3'd7, 12'h001);
    step("R10", 1'b1, 4'h0, 1'b1, 4'h0);
    vin_code = 12'd143;                           // below turn-off 144
    step("R4", 1'b0, 4'h2, 1'b1, 4'h2);
    vin_code = 12'd150;
    step("R4", 1'b0, 4'h2);
    vin_code = 12'd160;                           // equal to turn-on: still held
    step("R4", 1'b0, 4'h2);
    vin_code = 12'd161;
    step("R4", 1'b1, 4'h0);
    step("R4", 1'b1, 4'h0);
    temp_code = 12'd126;
    step("R5", 1'b0, 4'h8, 1'b1, 4'hA);
    temp_code = 12'd125;
    step("R5", 1'b1, 4'h0);
    wr(3'd7, 12'h00F);
    step("R10", 1'b1, 4'h0, 1'b1, 4'h0);
    vin_code = 12'd241; wr(3'd7, 12'h001);        // set wins over clear
    step("R10", 1'b0, 4'h1, 1'b1, 4'h1);
    vin_code = 12'd192;
    step("R3", 1'b1, 4'h0);
    step("R3", 1'b1, 4'h0);
    vin_code = 12'd241; vout_code = 12'd60;
    step("R3", 1'b0, 4'h1);
    vin_code = 12'd192;                           // output above setpoint 48
    step("R6", 1'b0, 4'h0);
    step("R6", 1'b0, 4'h0);
    vout_code = 12'd4;
    step("R6", 1'b1, 4'h0);
    for (int i = 1; i < 20; i++) begin
      tick_1k = 1'b1;
      step("R8", 1'b1, 4'h0);
    end
    tick_1k = 1'b1;
    step("R8", 1'b0, 4'h4, 1'b1, 4'h5);
    for (int i = 1; i < 20; i++) begin
      tick_1k = 1'b1;
      step("R9", 1'b0, 4'h4);
    end
    tick_1k = 1'b1;
    step("R9", 1'b0, 4'h0);
    step("R9", 1'b1, 4'h0);
    wr(3'd5, 12'd3);
    step("R11", 1'b1, 4'h0);
    wr(3'd6, 12'd2);
    step("R11", 1'b1, 4'h0);
    tick_1k = 1'b1; step("R11", 1'b1, 4'h0);
    tick_1k = 1'b1; step("R11", 1'b1, 4'h0);
    tick_1k = 1'b1; step("R11", 1'b0, 4'h4);
    tick_1k = 1'b1; step("R11", 1'b0, 4'h4);
    tick_1k = 1'b1; step("R11", 1'b0, 4'h0);
    step("R9", 1'b1, 4'h0);
    vout_code = 12'd16;
    step("R7", 1'b1, 4'h0);
    tick_1k = 1'b1;                               // no timeout once up
    step("R7", 1'b1, 4'h0);
    wr(3'd0, 12'd200);
    step("R11", 1'b1, 4'h0);
    vin_code = 12'd201;
    step("R11", 1'b0, 4'h1);
    vin_code = 12'd199;
    step("R11", 1'b1, 4'h0);
    uvlo_ok = 1'b0;
    wr(3'd7, 12'h00F);
    step("R2", 1'b0, 4'h0, 1'b1, 4'h0);
    vin_code = 12'd255;
    step("R2", 1'b0, 4'h0, 1'b1, 4'h0);
    repeat (2) @(posedge clk);
    @(negedge clk); #1;
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule